// File: doc/BRIEF.md
# Pin-Ownership GPIO Port

An eight-pin general-purpose I/O slice for a microcontroller peripheral bus. Every pin is either driven from a software-written data latch or taken over by a peripheral output. The peripheral sources are pulse-width modulation, a timer channel and, on one selected pin only, a routed serial line. A fixed ranking decides which source owns each pin. The port also produces per-pin output enables. Pin levels are synchronized, and they feed both a read path and a rising-edge interrupt unit.

Software reads the data register and gets a different answer depending on the direction bit. A pin set as output returns the stored latch bit. A pin set as input returns the synchronized pin level. A separate read-only input view always returns the synchronized level. Comparing the two views shows when an output pin is being pulled against its driven value, for example by a short or an overload. The peripherals themselves are outside the block and appear only as enable and data inputs.

The bus is a simple register port. Writes take effect at the clock edge where `bus_wr` is high. Read data is registered from `bus_addr` and appears one cycle later. Pin outputs, output enables and the interrupt line are registered.

Top module: `gpio_port_arb`

## Requirements
- R1: Under synchronous active-high reset, the data latch, direction, interrupt-enable and interrupt-flag registers clear to 0. After reset, `pin_oe` and `irq` are 0.
- R2: Reading address 0 (data) returns, for each bit, the latch bit where the direction bit (address 1) is 1. Where the direction bit is 0, it returns the synchronized pin level.
- R3: Reading address 2 (input view) returns the synchronized pin level for every bit, whatever the direction and ownership. Writes to address 2 change nothing. Reset does not clear the synchronizer.
- R4: For any pin other than the serial pin, ownership ranks PWM first, then timer, then the data latch. `pin_out` carries the winning source's data.
- R5: On the serial pin (bit `SER_PIN`, default 1), the ranking is PWM, then timer, then serial, then the data latch.
- R6: A pin with no enabled peripheral drives its latch bit on `pin_out`. Its `pin_oe` equals its direction bit.
- R7: `pin_oe` is 1 for any pin owned by an enabled peripheral, regardless of its direction bit.
- R8: A rising edge of a synchronized pin whose enable bit (address 3) is 1 sets that pin's sticky flag (address 4). This happens in input mode and in output mode alike. A disabled pin sets no flag.
- R9: Writing a 1 to a flag bit clears it, and writing 0 leaves it set. If an edge arrives in the same cycle as the clear, the edge wins.
- R10: `irq` is the registered OR of the flag bits whose enable is set. It rises one cycle after the flag is set.
- R11: A pin change becomes visible after two synchronizer stages. A read whose address is presented in the cycle right after the change still returns the old level, and the read after that one returns the new level.
- R12: `pin_out`, `pin_oe` and read data are registered and follow their inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Raw pin levels |
| pwm_en | input | WIDTH | Per-pin PWM ownership request |
| pwm_dat | input | WIDTH | PWM output data |
| tmr_en | input | WIDTH | Per-pin timer ownership request |
| tmr_dat | input | WIDTH | Timer output data |
| ser_en | input | 1 | Serial routing request for the serial pin |
| ser_dat | input | 1 | Serial output data |
| pin_out | output | WIDTH | Registered pin drive value |
| pin_oe | output | WIDTH | Registered pin output enable |
| irq | output | 1 | Combined pin interrupt |

## Verification
A wrong ownership decision shows on `pin_out` or `pin_oe` one cycle after the enables change. The bench sweeps every combination of enables and direction on every pin, so each such error appears there. A corrupted flag or enable register shows on `irq` one cycle later, and on the next read of address 4. A synchronizer with the wrong depth moves the input-view change one read earlier or later, and the latency check catches that shift.

// File: rtl/gpio_arb_pkg.sv
package gpio_arb_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_DIR   = 3'd1,
    A_PIN   = 3'd2,
    A_IEN   = 3'd3,
    A_IFLAG = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_GPIO = 2'd0,
    SRC_SER  = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_PWM  = 2'd3
  } pin_src_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_owner.sv
module gpio_pin_owner
  import gpio_arb_pkg::*;
#(
  parameter bit HAS_SER = 1'b0
) (
  input  logic pwm_en_i,
  input  logic pwm_dat_i,
  input  logic tmr_en_i,
  input  logic tmr_dat_i,
  input  logic ser_en_i,
  input  logic ser_dat_i,
  input  logic dir_i,
  input  logic latch_i,
  output logic out_o,
  output logic oe_o
);
  pin_src_e src;
  logic     ser_req;

  if (HAS_SER) begin : g_ser
    assign ser_req = ser_en_i;
  end else begin : g_noser
    logic unused_ser;
    assign unused_ser = ser_en_i ^ ser_dat_i;
    assign ser_req    = 1'b0;
  end

  always_comb begin
    if (pwm_en_i)      src = SRC_PWM;
    else if (tmr_en_i) src = SRC_TMR;
    else if (ser_req)  src = SRC_SER;
    else               src = SRC_GPIO;
  end

  always_comb begin
    unique case (src)
      SRC_PWM: begin out_o = pwm_dat_i; oe_o = 1'b1;  end
      SRC_TMR: begin out_o = tmr_dat_i; oe_o = 1'b1;  end
      SRC_SER: begin out_o = ser_dat_i; oe_o = 1'b1;  end
      default: begin out_o = latch_i;   oe_o = dir_i; end
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] ien_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] rise;

  always_ff @(posedge clk) begin
    prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q & ien_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_i) | rise;
      irq_o  <= |(flag_q & ien_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_port_arb.sv
module gpio_port_arb
  import gpio_arb_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SER_PIN     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WIDTH-1:0]    bus_wdata,
  output logic [WIDTH-1:0]    bus_rdata,
  input  logic [WIDTH-1:0]    pin_in,
  input  logic [WIDTH-1:0]    pwm_en,
  input  logic [WIDTH-1:0]    pwm_dat,
  input  logic [WIDTH-1:0]    tmr_en,
  input  logic [WIDTH-1:0]    tmr_dat,
  input  logic                ser_en,
  input  logic                ser_dat,
  output logic [WIDTH-1:0]    pin_out,
  output logic [WIDTH-1:0]    pin_oe,
  output logic                irq
);
  logic [WIDTH-1:0] latch_q, dir_q, ien_q;
  logic [WIDTH-1:0] sync_lvl, iflag, clr_mask;
  logic [WIDTH-1:0] out_c, oe_c;
  logic [WIDTH-1:0] rd_c;

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .raw_i(pin_in), .sync_o(sync_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:  latch_q <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_IEN:   ien_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr_mask = (bus_wr && bus_addr == A_IFLAG) ? bus_wdata : '0;

  gpio_edge_irq #(.WIDTH(WIDTH)) irq_i (
    .clk(clk), .rst(rst), .level_i(sync_lvl), .ien_i(ien_q),
    .clr_i(clr_mask), .flag_o(iflag), .irq_o(irq)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    gpio_pin_owner #(.HAS_SER(i == SER_PIN)) own_i (
      .pwm_en_i(pwm_en[i]), .pwm_dat_i(pwm_dat[i]),
      .tmr_en_i(tmr_en[i]), .tmr_dat_i(tmr_dat[i]),
      .ser_en_i(ser_en),    .ser_dat_i(ser_dat),
      .dir_i(dir_q[i]),     .latch_i(latch_q[i]),
      .out_o(out_c[i]),     .oe_o(oe_c[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= out_c;
      pin_oe  <= oe_c;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  rd_c = (latch_q & dir_q) | (sync_lvl & ~dir_q);
      A_DIR:   rd_c = dir_q;
      A_PIN:   rd_c = sync_lvl;
      A_IEN:   rd_c = ien_q;
      A_IFLAG: rd_c = iflag;
      default: rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    bus_rdata <= rd_c;
  end
endmodule

// File: rtl/gpio_port_arb_chk.sv
module gpio_port_arb_chk
  import gpio_arb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  pwm_en,
  input logic [WIDTH-1:0]  pwm_dat,
  input logic [WIDTH-1:0]  tmr_en,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe,
  input logic              irq,
  input logic [WIDTH-1:0]  flag,
  input logic [WIDTH-1:0]  ien,
  input logic [WIDTH-1:0]  dir
);
  logic [WIDTH-1:0] keep;
  assign keep = (bus_wr && bus_addr == A_IFLAG) ? (flag & ~bus_wdata) : flag;

  p_pwm_wins_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out ^ $past(pwm_dat)) & $past(pwm_en)) == '0);

  p_alt_oe_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe & $past(pwm_en | tmr_en)) == $past(pwm_en | tmr_en));

  p_dir_oe_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe & $past(dir)) == $past(dir));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag & $past(keep)) == $past(keep));

  p_irq_or_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(flag & ien)));
endmodule

bind gpio_port_arb gpio_port_arb_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pwm_en(pwm_en), .pwm_dat(pwm_dat),
  .tmr_en(tmr_en), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .flag(iflag), .ien(ien_q), .dir(dir_q)
);

// File: tb/gpio_port_arb_tb_top.sv
module gpio_port_arb_tb_top;
  localparam int W   = 8;
  localparam int SER = 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = 3'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pwm_en = '0, pwm_dat = '0, tmr_en = '0, tmr_dat = '0;
  logic         ser_en = 1'b0, ser_dat = 1'b0;
  logic [W-1:0] pin_out, pin_oe;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_arb #(.WIDTH(W), .SER_PIN(SER)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pwm_en(pwm_en), .pwm_dat(pwm_dat), .tmr_en(tmr_en), .tmr_dat(tmr_dat),
    .ser_en(ser_en), .ser_dat(ser_dat), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [1:0] exp_pin(input int i, input logic pe, input logic pd,
      input logic te, input logic td, input logic se, input logic sd,
      input logic dr, input logic lt);
    if (pe) return {1'b1, pd};
    if (te) return {1'b1, td};
    if (i == SER && se) return {1'b1, sd};
    return {dr, lt};
  endfunction

  task automatic check_pins(input string req, input logic [W-1:0] dr, input logic [W-1:0] lt);
    logic [W-1:0] eo, ee;
    for (int i = 0; i < W; i++) begin
      logic [1:0] r;
      r = exp_pin(i, pwm_en[i], pwm_dat[i], tmr_en[i], tmr_dat[i], ser_en, ser_dat, dr[i], lt[i]);
      ee[i] = r[1]; eo[i] = r[0];
    end
    @(negedge clk);
    chk({req, " out"}, pin_out, eo);
    chk({req, " oe"}, pin_oe, ee);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 oe", pin_oe, '0);
    chk("R1 irq", {7'd0, irq}, '0);
    rd(3'd0, v); chk("R1 data(pins low)", v, '0);
    rd(3'd1, v); chk("R1 dir", v, '0);
    rd(3'd3, v); chk("R1 ien", v, '0);
    rd(3'd4, v); chk("R1 flag", v, '0);

    // R11 synchronizer latency, R3 input view
    pin_in = 8'h5A;
    bus_addr = 3'd2;
    @(negedge clk); chk("R11 old level 1", bus_rdata, 8'h00);
    @(negedge clk); chk("R11 old level 2", bus_rdata, 8'h00);
    @(negedge clk); chk("R11 new level", bus_rdata, 8'h5A);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); chk("R3 write ignored", v, 8'h5A);
    rd(3'd0, v); chk("R2 input dir reads pins", v, 8'h5A);

    // R2 mixed direction sweep
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] dr, lt, pv;
      dr = W'(k * 8'h1F); lt = W'(k * 8'h35 + 3); pv = W'(k * 8'h4B + 1);
      pin_in = pv;
      wr(3'd1, dr); wr(3'd0, lt);
      tick(2);
      rd(3'd0, v); chk("R2 data read", v, (lt & dr) | (pv & ~dr));
      rd(3'd2, v); chk("R3 input view", v, pv);
    end

    // R4 R5 R6 R7 exhaustive enable/dir sweep
    pwm_dat = 8'hA5; tmr_dat = 8'h3C;
    for (int k = 0; k < 32; k++) begin
      pwm_en = {W{k[0]}}; tmr_en = {W{k[1]}}; ser_en = k[2];
      ser_dat = ~k[4];
      wr(3'd1, {W{k[3]}}); wr(3'd0, 8'h96);
      check_pins("R4 R5 R6 R7 sweep", {W{k[3]}}, 8'h96);
    end
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] dr;
      pwm_en = W'(k * 37); tmr_en = W'(k * 91 + 5); ser_en = k[1];
      pwm_dat = W'(k * 13); tmr_dat = W'(~(k * 29)); ser_dat = k[2];
      dr = W'(k * 71);
      wr(3'd1, dr); wr(3'd0, W'(k * 53));
      check_pins("R4 R5 R7 mixed", dr, W'(k * 53));
    end
    pwm_en = '0; tmr_en = '0; ser_en = 1'b0;
    wr(3'd1, 8'hF0); wr(3'd0, 8'hC3);
    check_pins("R6 gpio only", 8'hF0, 8'hC3);
    // R12 registered: change enable, old value still held before edge
    bus_addr = 3'd1;
    pwm_en = 8'hFF; pwm_dat = 8'h00;
    #1 chk("R12 held", pin_out, 8'hC3);
    @(negedge clk); chk("R12 updated", pin_out, 8'h00);
    pwm_en = '0;

    // R8 R9 R10 interrupts
    pin_in = '0; tick(3);
    wr(3'd3, 8'h0F);
    pin_in = 8'h81;          // bit0 enabled, bit7 disabled; bit0 is output (dir F0? no) 
    tick(3);
    chk("R10 irq not yet", {7'd0, irq}, '0);
    rd(3'd4, v); chk("R8 flag set enabled only", v, 8'h01);
    chk("R10 irq raised", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R9 write 0 keeps", v, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R9 write 1 clears", v, 8'h00);
    chk("R10 irq cleared", {7'd0, irq}, 8'h00);
    // output-mode pin edge (bit 2 out via dir) R8
    wr(3'd1, 8'h04);
    pin_in = 8'h85; tick(3);
    rd(3'd4, v); chk("R8 output-mode edge", v, 8'h04);
    // enable change with stored flag: irq follows mask R10
    wr(3'd3, 8'h00); tick(1);
    chk("R10 masked", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h04); tick(1);
    chk("R10 unmasked", {7'd0, irq}, 8'h01);
    // R9 edge wins over simultaneous clear: clear bit3 at its set cycle
    wr(3'd3, 8'h08);
    pin_in = 8'h8D;
    tick(2);                 // after 2 edges: sync new, rise computed next edge
    wr(3'd4, 8'h08);
    rd(3'd4, v); chk("R9 set wins", v, 8'h0C);

    // R1 reset again, input view not cleared (R3)
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    rd(3'd4, v); chk("R1 flag cleared", v, 8'h00);
    rd(3'd2, v); chk("R3 input survives reset", v, 8'h8D);
    chk("R1 oe after reset", pin_oe, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule